// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage, in-order integer pipeline. It decides where each of the two ALU operands comes from. The choices are the value read from the register file, the result held one stage ahead in the execute/memory register, or the result held two stages ahead in the memory/writeback register. It also decides whether the write data for a store in the memory stage should be replaced by a value that a load has just fetched. The block contains the operand multiplexers too, so the bypassed data values appear on its outputs. It has no clock: every output follows its inputs.

The rules for the two operands are the same. A match against the younger result (execute/memory) takes precedence over a match against the older one (memory/writeback), so a register that is written twice in a row supplies its newest value. Register 0 always reads as zero and is never bypassed. Each instruction writes at most one register, so each pipeline register offers a single candidate.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2 when `exmem_wr` is 1, `exmem_rd` equals `ex_rs` and `exmem_rd` is not 0. Select encoding: 0 is the register file, 1 is the memory/writeback result, 2 is the execute/memory result; 3 never appears.
- R2: `sel_b` is 2 under the same condition as R1, with `ex_rt` compared in place of `ex_rs`.
- R3: A select is 1 when `memwb_wr` is 1, `memwb_rd` equals that operand's source register, `memwb_rd` is not 0, and the R1/R2 condition for that operand does not hold.
- R4: When both pipeline registers write the operand's source register (not 0), the select is 2 and the operand carries `exmem_result`.
- R5: A destination equal to register 0 never causes a select other than 0, on `sel_a`, `sel_b` or `sel_c`.
- R6: With neither write flag matching, each select is 0 and each operand equals its register-file input.
- R7: `alu_a` and `alu_b` equal `rf_a`/`rf_b` for select 0, `memwb_result` for select 1, and `exmem_result` for select 2.
- R8: `sel_c` is 1 when `memwb_wr` and `memwb_load` are both 1, `memwb_rd` equals `mem_st_reg` and is not 0. While `sel_c` is 1, `store_data` equals `memwb_result`. Otherwise it equals `mem_st_data`.
- R9: A register-writing non-load (`memwb_load` = 0) in memory/writeback never asserts `sel_c`, even if its destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_AW | Execute-stage first source register |
| ex_rt | input | REG_AW | Execute-stage second source register |
| exmem_rd | input | REG_AW | Destination held in execute/memory register |
| exmem_wr | input | 1 | Execute/memory instruction writes a register |
| memwb_rd | input | REG_AW | Destination held in memory/writeback register |
| memwb_wr | input | 1 | Memory/writeback instruction writes a register |
| memwb_load | input | 1 | Memory/writeback instruction is a load |
| mem_st_reg | input | REG_AW | Data register of the store in the memory stage |
| rf_a | input | DATA_W | Register-file value for first operand |
| rf_b | input | DATA_W | Register-file value for second operand |
| exmem_result | input | DATA_W | Result held in execute/memory register |
| memwb_result | input | DATA_W | Result (or load data) held in memory/writeback register |
| mem_st_data | input | DATA_W | Store write data carried into memory stage |
| sel_a | output | 2 | First operand source select |
| sel_b | output | 2 | Second operand source select |
| sel_c | output | 1 | Store data bypass select |
| alu_a | output | DATA_W | Selected first ALU operand |
| alu_b | output | DATA_W | Selected second ALU operand |
| store_data | output | DATA_W | Selected data-memory write data |

## Verification
The bench sweeps every combination of register numbers, write flags and the load flag on a 2-bit register index. This covers the double-write case: a design that let the older result win there would feed a stale value to the ALU. It also covers register 0 as a destination, where a design that bypassed it would replace the constant zero with a result that was never written. A load-versus-non-load destination match checks that a plain ALU result is not pushed into store data. Each operand value is checked against the select so that a swapped multiplexer leg shows up as a wrong data word.

// File: rtl/fwd_pkg.sv
// Shared definitions for the operand bypass selector.
// Assumes a two-bit select is wide enough for three sources.
package fwd_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_WB  = 2'd1,
        SRC_MEM = 2'd2
    } fwd_src_e;
endpackage

// File: rtl/fwd_operand_sel.sv
// Chooses the source of one ALU operand from the two older pipeline stages.
// Assumes register 0 is hard-wired to zero; younger result wins on a tie.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_wr,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_wr,
    output logic [1:0]        sel
);
    logic hit_mem;
    logic hit_wb;

    // Detect a live, nonzero destination match in each stage.
    always_comb begin
        hit_mem = exmem_wr && (exmem_rd != '0) && (exmem_rd == src_reg);
        hit_wb  = memwb_wr && (memwb_rd != '0) && (memwb_rd == src_reg);
    end

    // Prioritise the younger stage, fall back to the register file.
    always_comb begin
        if (hit_mem)     sel = SRC_MEM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/fwd_store_sel.sv
// Decides whether store write data is replaced by a just-loaded value.
// Assumes the memory/writeback data input carries the loaded word for loads.
module fwd_store_sel #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_wr,
    input  logic              memwb_load,
    input  logic [REG_AW-1:0] st_reg,
    output logic              sel
);
    // Only a register-writing load into a nonzero matching register bypasses.
    always_comb begin
        sel = memwb_wr && memwb_load && (memwb_rd != '0) && (memwb_rd == st_reg);
    end
endmodule

// File: rtl/fwd_mux3.sv
// Three-way data selector driven by a bypass source code.
// Assumes the unused code value falls back to the register file leg.
module fwd_mux3
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] out
);
    // Steer the chosen source to the output.
    always_comb begin
        case (fwd_src_e'(sel))
            SRC_MEM: out = mem_val;
            SRC_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
// Top of the operand bypass selector: two operand selectors with their muxes
// plus the load-to-store data bypass. Purely combinational.
// Assumes each instruction writes at most one destination register.
module fwd_unit #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_wr,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_wr,
    input  logic              memwb_load,
    input  logic [REG_AW-1:0] mem_st_reg,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] exmem_result,
    input  logic [DATA_W-1:0] memwb_result,
    input  logic [DATA_W-1:0] mem_st_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              sel_c,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    output logic [DATA_W-1:0] store_data
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] op_src [NUM_OPS];
    logic [DATA_W-1:0] op_rf  [NUM_OPS];
    logic [1:0]        op_sel [NUM_OPS];
    logic [DATA_W-1:0] op_out [NUM_OPS];

    // Gather per-operand inputs into arrays.
    always_comb begin
        op_src[0] = ex_rs;
        op_src[1] = ex_rt;
        op_rf[0]  = rf_a;
        op_rf[1]  = rf_b;
    end

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        fwd_operand_sel #(.REG_AW(REG_AW)) sel_i (
            .src_reg  (op_src[gi]),
            .exmem_rd (exmem_rd),
            .exmem_wr (exmem_wr),
            .memwb_rd (memwb_rd),
            .memwb_wr (memwb_wr),
            .sel      (op_sel[gi])
        );
        fwd_mux3 #(.DATA_W(DATA_W)) mux_i (
            .sel     (op_sel[gi]),
            .rf_val  (op_rf[gi]),
            .mem_val (exmem_result),
            .wb_val  (memwb_result),
            .out     (op_out[gi])
        );
    end

    fwd_store_sel #(.REG_AW(REG_AW)) st_sel_i (
        .memwb_rd   (memwb_rd),
        .memwb_wr   (memwb_wr),
        .memwb_load (memwb_load),
        .st_reg     (mem_st_reg),
        .sel        (sel_c)
    );

    // Drive the outputs from the per-operand results and store bypass.
    always_comb begin
        sel_a      = op_sel[0];
        sel_b      = op_sel[1];
        alu_a      = op_out[0];
        alu_b      = op_out[1];
        store_data = sel_c ? memwb_result : mem_st_data;
    end
endmodule

// File: rtl/fwd_unit_chk.sv
// Invariant checker for the bypass selector, bound to every instance.
// Assumes inputs settle within a time step; uses immediate assertions only.
module fwd_unit_chk #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_AW-1:0] ex_rs,
    input logic [REG_AW-1:0] ex_rt,
    input logic [REG_AW-1:0] exmem_rd,
    input logic              exmem_wr,
    input logic [REG_AW-1:0] memwb_rd,
    input logic              memwb_wr,
    input logic              memwb_load,
    input logic [REG_AW-1:0] mem_st_reg,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic [DATA_W-1:0] exmem_result,
    input logic [DATA_W-1:0] memwb_result,
    input logic [DATA_W-1:0] mem_st_data,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic              sel_c,
    input logic [DATA_W-1:0] alu_a,
    input logic [DATA_W-1:0] alu_b,
    input logic [DATA_W-1:0] store_data
);
    // Check select legality, its justification and the data it steers.
    always_comb begin
        p_sel_legal_r1: assert (sel_a != 2'd3 && sel_b != 2'd3);
        p_mem_just_r2: assert (sel_b != 2'd2 || (exmem_wr && exmem_rd == ex_rt));
        p_wb_just_r3: assert (sel_a != 2'd1 || (memwb_wr && memwb_rd == ex_rs));
        p_newest_wins_r4: assert (!(exmem_wr && exmem_rd == ex_rs && ex_rs != '0) || sel_a == 2'd2);
        p_zero_never_r5: assert (ex_rs != '0 || sel_a == 2'd0);
        p_mux_data_r7: assert (sel_a != 2'd2 || alu_a == exmem_result);
        p_store_load_r9: assert (!sel_c || (memwb_load && store_data == memwb_result));
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/fwd_unit_tb_top.sv
// Exhaustive sweep of the bypass selector on a 2-bit register index.
module fwd_unit_tb_top;
    localparam int AW = 2;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] ex_rs = '0, ex_rt = '0, exmem_rd = '0, memwb_rd = '0, mem_st_reg = '0;
    logic exmem_wr = 1'b0, memwb_wr = 1'b0, memwb_load = 1'b0;
    logic [DW-1:0] rf_a = '0, rf_b = '0, exmem_result = '0, memwb_result = '0, mem_st_data = '0;
    logic [1:0] sel_a, sel_b;
    logic sel_c;
    logic [DW-1:0] alu_a, alu_b, store_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fwd_unit #(.REG_AW(AW), .DATA_W(DW)) dut_i (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .exmem_rd(exmem_rd), .exmem_wr(exmem_wr),
        .memwb_rd(memwb_rd), .memwb_wr(memwb_wr), .memwb_load(memwb_load),
        .mem_st_reg(mem_st_reg), .rf_a(rf_a), .rf_b(rf_b),
        .exmem_result(exmem_result), .memwb_result(memwb_result),
        .mem_st_data(mem_st_data), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .alu_a(alu_a), .alu_b(alu_b), .store_data(store_data)
    );

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] src);
        if (exmem_wr && exmem_rd != 0 && exmem_rd == src) return 2'd2;
        if (memwb_wr && memwb_rd != 0 && memwb_rd == src) return 2'd1;
        return 2'd0;
    endfunction

    function automatic string sel_tag(input logic [AW-1:0] src, input string r_mem);
        bit m = exmem_wr && exmem_rd == src;
        bit w = memwb_wr && memwb_rd == src;
        if (src == 0 && (m || w)) return "R5";
        if (m && w) return "R4";
        if (m) return r_mem;
        if (w) return "R3";
        return "R6";
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic [1:0] s, input logic [DW-1:0] rf);
        if (s == 2'd2) return exmem_result;
        if (s == 2'd1) return memwb_result;
        return rf;
    endfunction

    task automatic check_all();
        logic [1:0] ea, eb;
        logic ec;
        string ctag;
        ea = exp_sel(ex_rs);
        eb = exp_sel(ex_rt);
        ec = memwb_wr && memwb_load && memwb_rd != 0 && memwb_rd == mem_st_reg;
        ctag = (memwb_wr && !memwb_load && memwb_rd == mem_st_reg) ? "R9" :
               (memwb_rd == 0 && mem_st_reg == 0) ? "R5" : "R8";
        chk(sel_tag(ex_rs, "R1"), "sel_a", DW'(sel_a), DW'(ea));
        chk(sel_tag(ex_rt, "R2"), "sel_b", DW'(sel_b), DW'(eb));
        chk("R7", "alu_a", alu_a, exp_data(ea, rf_a));
        chk("R7", "alu_b", alu_b, exp_data(eb, rf_b));
        chk(ctag, "sel_c", DW'(sel_c), DW'(ec));
        chk("R8", "store_data", store_data, ec ? memwb_result : mem_st_data);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exmem_result = 32'hE000;
        memwb_result = 32'hB000;
        mem_st_data  = 32'h5000;
        // Idle state: all inputs zero, nothing bypassed (R6).
        @(negedge clk);
        #1;
        chk("R6", "idle sel_a", DW'(sel_a), 0);
        chk("R6", "idle alu_a", alu_a, rf_a);

        // Double write of the same register: newest result wins (R4).
        @(negedge clk);
        ex_rs = 2'd1; exmem_rd = 2'd1; memwb_rd = 2'd1; exmem_wr = 1; memwb_wr = 1;
        rf_a = 32'h101;
        #1;
        chk("R4", "dbl sel_a", DW'(sel_a), 2);
        chk("R4", "dbl alu_a", alu_a, 32'hE000);

        for (int v = 0; v < 8192; v++) begin
            @(negedge clk);
            ex_rs      = AW'(v);
            ex_rt      = AW'(v >> 2);
            exmem_rd   = AW'(v >> 4);
            memwb_rd   = AW'(v >> 6);
            mem_st_reg = AW'(v >> 8);
            exmem_wr   = v[10];
            memwb_wr   = v[11];
            memwb_load = v[12];
            rf_a = 32'h100 + DW'(ex_rs);
            rf_b = 32'h200 + DW'(ex_rt);
            #1;
            check_all();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule